// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a small 8-bit accumulator processor with hardwired control and a 64-byte on-block memory. Each instruction byte has a 2-bit opcode in bits 7:6 and a 6-bit memory address in bits 5:0. There are four operations: copy a memory byte into the accumulator, add a memory byte to the accumulator, copy the accumulator to memory, and an unconditional branch. The datapath has five registers: program counter (`pc_q`), instruction register (`ir_q`), address register (`mar_q`), data buffer (`mbr_q`) and accumulator (`ac_q`). It also has one adder whose result is held in a buffer register. The same adder, with its carry input raised and its accumulator operand masked, forms the incremented program counter during instruction fetch.

Sequencing comes from two small state registers. The phase is `PH_FETCH` or `PH_EXEC`. The step is `STEP1`..`STEP4`, decoded into one-hot ticks. Fetch always runs `STEP1`→`STEP2`→`STEP3`, then goes to `PH_EXEC`/`STEP1`. Execute leaves for `PH_FETCH`/`STEP1` at the last step of the current operation: `STEP1` for the branch, `STEP2` for the store, `STEP3` for the load, and `STEP4` for the add, where the step count wraps naturally. Every other step moves on to the next step in the same phase.

Memory is loaded through a preload port while reset is held. While the processor runs, only the program counter and the accumulator are visible.

Top module: `acc_cpu4`

## Requirements
- R1: While `rst` is high, `pc_out` and `ac_out` read 0 and a high `pre_we` writes `pre_data` into memory at `pre_addr`. After release, the first instruction is fetched from address 0.
- R2: Fetch lasts three clock edges. `pc_out` holds its value for the first two edges and becomes `pc_out+1` (mod 256) at the third edge. `ac_out` does not change during fetch.
- R3: Opcode 00 (load) lasts three execute edges. At the third edge `ac_out` takes the memory byte at address bits 5:0. A whole load instruction takes 6 cycles.
- R4: Opcode 01 (add) lasts four execute edges. At the fourth edge `ac_out` becomes (`ac_out` + memory byte) mod 256, with no overflow indication. A whole add instruction takes 7 cycles.
- R5: Opcode 11 (store) lasts two execute edges. At the second edge the accumulator value is written to memory at address bits 5:0, and `pc_out` and `ac_out` do not change. A whole store instruction takes 5 cycles.
- R6: Opcode 10 (branch) lasts one execute edge. At that edge `pc_out` becomes bits 5:0 zero-extended to 8 bits. A whole branch instruction takes 4 cycles.
- R7: The program counter wraps from 0xFF to 0x00. Instructions are fetched from memory at `pc_out` bits 5:0.
- R8: Execute-step controls are qualified by the phase. The fetch that follows an add leaves `ac_out` unchanged.
- R9: A high `pre_we` while `rst` is low has no effect on memory.
- R10: A store to the address of the next instruction takes effect before that instruction is fetched, so the newly written byte is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; enables preload |
| pre_we | input | 1 | Preload write strobe, honoured only during reset |
| pre_addr | input | 6 | Preload byte address |
| pre_data | input | 8 | Preload byte value |
| pc_out | output | 8 | Program counter value |
| ac_out | output | 8 | Accumulator value |

## Verification
Two functions can land on the same clock edge. In the second fetch step, the memory read into the buffer and the program counter increment through the shared adder happen together. A store to the following address also writes memory on the edge just before the fetch of that address begins. The bench checks both with a reference that steps every instruction edge by edge and predicts `pc_out` and `ac_out` after each edge. In one program, the accumulator holds a branch encoding and the next instruction stores it over the following instruction. The run passes only if the program counter then follows the new branch target and not the original byte.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;

    // Operation field encoding (bits 7:6 of the instruction byte)
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_JUMP  = 2'b10,
        OP_STORE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        STEP1 = 2'd0,
        STEP2 = 2'd1,
        STEP3 = 2'd2,
        STEP4 = 2'd3
    } step_e;

    typedef enum logic {
        PH_EXEC  = 1'b0,
        PH_FETCH = 1'b1
    } phase_e;

    // Datapath control word for one step
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic mem_wr;
        logic buf_en;
        logic sel_pc;
        logic carry_in;
        logic pc_from_buf;
        logic pc_from_ir;
        logic ir_from_mbr;
        logic ac_from_mbr;
        logic ac_from_buf;
    } ctl_s;

endpackage

// File: rtl/cpu4_ctrl.sv
module cpu4_ctrl
    import cpu4_pkg::*;
#(
    parameter int NSTEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  opcode_e          opcode,
    output step_e            step,
    output phase_e           phase,
    output logic [NSTEP-1:0] tick,
    output ctl_s             ctl
);
    localparam int NOPS = 4;

    step_e      step_nxt;
    phase_e     phase_nxt;
    logic [NOPS-1:0] op_hot;
    logic       is_l, is_a, is_j, is_s;

    // one-hot operation decoder
    for (genvar g = 0; g < NOPS; g++) begin : g_opdec
        assign op_hot[g] = (opcode == opcode_e'(g));
    end
    assign is_l = op_hot[OP_LOAD];
    assign is_a = op_hot[OP_ADD];
    assign is_j = op_hot[OP_JUMP];
    assign is_s = op_hot[OP_STORE];

    // one-hot step ticks
    for (genvar g = 0; g < NSTEP; g++) begin : g_tick
        assign tick[g] = (step == step_e'(g));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= STEP1;
            phase <= PH_FETCH;
        end else begin
            step  <= step_nxt;
            phase <= phase_nxt;
        end
    end

    // next state: early return to STEP1 at each operation's last step
    always_comb begin
        step_nxt  = step_e'(step + 2'd1);
        phase_nxt = phase;
        unique case (phase)
            PH_FETCH: begin
                if (step == STEP3) begin
                    step_nxt  = STEP1;
                    phase_nxt = PH_EXEC;
                end
            end
            PH_EXEC: begin
                unique case (step)
                    STEP1: if (is_j) begin step_nxt = STEP1; phase_nxt = PH_FETCH; end
                    STEP2: if (is_s) begin step_nxt = STEP1; phase_nxt = PH_FETCH; end
                    STEP3: if (is_l) begin step_nxt = STEP1; phase_nxt = PH_FETCH; end
                    STEP4: begin step_nxt = STEP1; phase_nxt = PH_FETCH; end
                endcase
            end
        endcase
    end

    // control outputs
    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_FETCH: begin
                unique case (step)
                    STEP1: ctl.mar_from_pc = 1'b1;
                    STEP2: begin
                        ctl.mbr_from_mem = 1'b1;
                        ctl.buf_en       = 1'b1;
                        ctl.sel_pc       = 1'b1;
                        ctl.carry_in     = 1'b1;
                    end
                    STEP3: begin
                        ctl.pc_from_buf = 1'b1;
                        ctl.ir_from_mbr = 1'b1;
                    end
                    STEP4: ctl = '0;
                endcase
            end
            PH_EXEC: begin
                unique case (step)
                    STEP1: begin
                        ctl.mar_from_ir = is_l | is_a | is_s;
                        ctl.mbr_from_ac = is_s;
                        ctl.pc_from_ir  = is_j;
                    end
                    STEP2: begin
                        ctl.mbr_from_mem = is_l | is_a;
                        ctl.mem_wr       = is_s;
                    end
                    STEP3: begin
                        ctl.ac_from_mbr = is_l;
                        ctl.buf_en      = is_a;
                    end
                    STEP4: ctl.ac_from_buf = is_a;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/cpu4_alu.sv
module cpu4_alu #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sel_pc,
    input  logic          carry_in,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] mbr,
    output logic [DW-1:0] sum_q
);
    logic [DW-1:0] opa, opb, sum;

    // accumulator operand is masked while the program counter is incremented
    assign opa = sel_pc ? '0 : acc;
    assign opb = sel_pc ? pc : mbr;
    assign sum = opa + opb + {{(DW-1){1'b0}}, carry_in};

    always_ff @(posedge clk) begin
        if (rst)     sum_q <= '0;
        else if (en) sum_q <= sum;
    end

endmodule

// File: rtl/cpu4_mem.sv
module cpu4_mem #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/acc_cpu4.sv
module acc_cpu4
    import cpu4_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] ac_out
);
    localparam int OPW   = 2;
    localparam int NSTEP = 4;

    logic [DW-1:0]    pc_q, ir_q, mbr_q, ac_q, alu_q, rdata, wdata;
    logic [AW-1:0]    mar_q, waddr;
    logic [NSTEP-1:0] tick;
    logic             mem_we;
    step_e            step;
    phase_e           phase;
    ctl_s             ctl;
    opcode_e          op;
    logic [DW-1:0]    ir_target;

    assign op        = opcode_e'(ir_q[DW-1 -: OPW]);
    assign ir_target = {{(DW-AW){1'b0}}, ir_q[AW-1:0]};

    cpu4_ctrl #(.NSTEP(NSTEP)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (op),
        .step   (step),
        .phase  (phase),
        .tick   (tick),
        .ctl    (ctl)
    );

    cpu4_alu #(.DW(DW)) u_alu (
        .clk      (clk),
        .rst      (rst),
        .en       (ctl.buf_en),
        .sel_pc   (ctl.sel_pc),
        .carry_in (ctl.carry_in),
        .acc      (ac_q),
        .pc       (pc_q),
        .mbr      (mbr_q),
        .sum_q    (alu_q)
    );

    // preload owns the write port only during reset
    assign mem_we = rst ? pre_we   : ctl.mem_wr;
    assign waddr  = rst ? pre_addr : mar_q;
    assign wdata  = rst ? pre_data : mbr_q;

    cpu4_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (mar_q),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            ac_q  <= '0;
        end else begin
            if (ctl.mar_from_pc)       mar_q <= pc_q[AW-1:0];
            else if (ctl.mar_from_ir)  mar_q <= ir_q[AW-1:0];
            if (ctl.mbr_from_mem)      mbr_q <= rdata;
            else if (ctl.mbr_from_ac)  mbr_q <= ac_q;
            if (ctl.pc_from_buf)       pc_q  <= alu_q;
            else if (ctl.pc_from_ir)   pc_q  <= ir_target;
            if (ctl.ir_from_mbr)       ir_q  <= mbr_q;
            if (ctl.ac_from_mbr)       ac_q  <= mbr_q;
            else if (ctl.ac_from_buf)  ac_q  <= alu_q;
        end
    end

    assign pc_out = pc_q;
    assign ac_out = ac_q;

endmodule

// File: rtl/acc_cpu4_chk.sv
module acc_cpu4_chk
    import cpu4_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          pre_we,
    input logic          mem_we,
    input logic [DW-1:0] pc_out,
    input logic [DW-1:0] ac_out,
    input step_e         step,
    input phase_e        phase,
    input opcode_e       op,
    input logic [AW-1:0] addr,
    input logic          pc_from_buf,
    input logic          pc_from_ir
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_out == '0 && ac_out == '0));

    // R2
    fetch_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && step == STEP3) |=> (phase == PH_EXEC && step == STEP1));

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_from_buf && !pc_from_ir) |=> $stable(pc_out));

    // R3
    load_end_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && step == STEP3 && op == OP_LOAD) |=> (phase == PH_FETCH && step == STEP1));

    // R5
    store_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_EXEC && step == STEP2 && op == OP_STORE));

    // R6
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && step == STEP1 && op == OP_JUMP) |=> (pc_out == DW'($past(addr))));

    // R8
    fetch_ac_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> $stable(ac_out));

    // R9
    preload_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_we && !(phase == PH_EXEC && step == STEP2 && op == OP_STORE)) |-> !mem_we);

endmodule

bind acc_cpu4 acc_cpu4_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pre_we      (pre_we),
    .mem_we      (mem_we),
    .pc_out      (pc_out),
    .ac_out      (ac_out),
    .step        (step),
    .phase       (phase),
    .op          (op),
    .addr        (ir_q[AW-1:0]),
    .pc_from_buf (ctl.pc_from_buf),
    .pc_from_ir  (ctl.pc_from_ir)
);

// File: tb/acc_cpu4_test.sv
module acc_cpu4_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [5:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [7:0] pc_out, ac_out;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    logic [7:0] prog [64];
    logic [7:0] mref [64];
    logic [7:0] q_pc [$];
    logic [7:0] q_ac [$];
    string      q_tag [$];

    bit         poke_en = 1'b0;
    logic [5:0] poke_a = '0;
    logic [7:0] poke_d = '0;

    always #5 clk = ~clk;

    acc_cpu4 uut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .pc_out(pc_out), .ac_out(ac_out)
    );

    task automatic push(input logic [7:0] p, input logic [7:0] a, input string t);
        q_pc.push_back(p);
        q_ac.push_back(a);
        q_tag.push_back(t);
    endtask

    // reference: one expected (pc, ac) item per clock edge
    task automatic build_trace(input int n);
        logic [7:0] pc = 8'h00;
        logic [7:0] ac = 8'h00;
        logic [7:0] inst;
        logic [5:0] a;
        bit prev_add = 1'b0;
        string ovr = "";
        string t;
        for (int i = 0; i < 64; i++) mref[i] = prog[i];
        for (int k = 0; k < n; k++) begin
            inst = mref[pc[5:0]];
            t = (pc == 8'hFF) ? "R7" : (prev_add ? "R8" : "R2");
            if (ovr != "") t = ovr;
            push(pc, ac, t);
            push(pc, ac, t);
            pc = pc + 8'd1;
            push(pc, ac, t);
            a = inst[5:0];
            prev_add = 1'b0;
            case (inst[7:6])
                2'b00: begin
                    if (ovr == "") t = (poke_en && a == poke_a) ? "R9" : "R3";
                    push(pc, ac, t); push(pc, ac, t);
                    ac = mref[a];
                    push(pc, ac, t);
                end
                2'b01: begin
                    if (ovr == "") t = "R4";
                    push(pc, ac, t); push(pc, ac, t); push(pc, ac, t);
                    ac = ac + mref[a];
                    push(pc, ac, t);
                    prev_add = 1'b1;
                end
                2'b11: begin
                    if (ovr == "") t = "R5";
                    push(pc, ac, t);
                    mref[a] = ac;
                    push(pc, ac, t);
                end
                default: begin
                    if (ovr == "") t = "R6";
                    pc = {2'b00, a};
                    push(pc, ac, t);
                end
            endcase
            ovr = (inst[7:6] == 2'b11 && a == pc[5:0]) ? "R10" : "";
        end
    endtask

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (running) begin
            if (q_pc.size() == 0) begin
                running = 1'b0;
            end else begin
                logic [7:0] ep, ea;
                string et;
                ep = q_pc.pop_front();
                ea = q_ac.pop_front();
                et = q_tag.pop_front();
                checks++;
                if (pc_out !== ep || ac_out !== ea) begin
                    errors++;
                    $display("FAIL %s pc=%h exp %h ac=%h exp %h", et, pc_out, ep, ac_out, ea);
                end
            end
        end
    end

    task automatic run_prog(input int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = 6'(i); pre_data = prog[i];
        end
        @(negedge clk);
        pre_we = 1'b0;
        // R1: reset state
        checks++;
        if (pc_out !== 8'h00 || ac_out !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset pc=%h ac=%h exp 00 00", pc_out, ac_out);
        end
        build_trace(n);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        running = 1'b1;
        if (poke_en) begin
            repeat (2) @(negedge clk);
            pre_we = 1'b1; pre_addr = poke_a; pre_data = poke_d;
            @(negedge clk);
            pre_we = 1'b0;
        end
        wait (running == 1'b0);
    endtask

    initial begin
        // program 1: load, adds with wrap, store, reload, branch back
        for (int i = 0; i < 64; i++) prog[i] = 8'h80;
        prog[0] = 8'h14; prog[1] = 8'h55; prog[2] = 8'h56;
        prog[3] = 8'hD7; prog[4] = 8'h17; prog[5] = 8'h80;
        prog[20] = 8'h11; prog[21] = 8'h22; prog[22] = 8'hF5; prog[23] = 8'h00;
        run_prog(14);

        // program 2: straight-line adds, PC runs past 0xFF (R7)
        for (int i = 0; i < 64; i++) prog[i] = 8'h7F;
        run_prog(260);

        // program 3: preload ignored while running (R9), store over next instruction (R10)
        for (int i = 0; i < 64; i++) prog[i] = 8'h80;
        prog[0] = 8'h1F; prog[1] = 8'h1E; prog[2] = 8'hC3; prog[3] = 8'h80;
        prog[30] = 8'h83; prog[31] = 8'h3C;
        poke_en = 1'b1; poke_a = 6'd31; poke_d = 8'hAA;
        run_prog(7);
        poke_en = 1'b0;

        // program 4: branch to the top address, zero extension and fetch wrap (R6, R7)
        for (int i = 0; i < 64; i++) prog[i] = 8'h80;
        prog[0] = 8'hBF; prog[63] = 8'h3E; prog[62] = 8'h9A;
        run_prog(6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule